// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block collects interrupt events from a link-side controller and folds them into one level-sensitive interrupt line for a host processor. Events arrive as single-cycle pulses: legacy line assert and deassert for up to four lines, power-state change, flush, and message-signalled interrupts. Each message carries a vector index and a payload. The events are latched into two cause registers and a message vector register. Per-bit masks then gate the causes into one summary bit, and a separate mask gates that summary bit onto the interrupt output.

Software reaches the block through a simple word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the current address. Every status register is cleared by writing ones. Every mask bit set to 1 suppresses its source. Message vectors roll up into one pending bit in cause register 0. That bit stays set for as long as any unmasked vector is still pending.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all status registers, the payload register and `irq_o` are 0. Every mask register holds 1 in each implemented bit: cause 0 mask reads 0x07FFFFFF, cause 1 mask reads 0x00000FF0, message mask reads 0xFFFFFFFF, summary mask reads 0x00010000.
- R2: A pulse on `leg_assert_i[n]` sets cause 0 bit 16+n. A pulse on `leg_deassert_i[n]` sets cause 0 bit 20+n. Both are visible after the edge that samples the pulse.
- R3: `pwr_i` sets cause 1 bit 4, `flush_i` sets cause 1 bit 5, and `leg_assert_i[n]` also sets cause 1 bit 8+n.
- R4: Writing a status register clears exactly the bits written as 1 and leaves the others unchanged. Writing all-ones clears every bit. Bits outside the implemented fields always read 0.
- R5: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: A pulse on `msi_valid_i` sets message vector bit `msi_vec_i` and captures `msi_payload_i` into the payload register, zero-extended to 32 bits.
- R7: Cause 0 bit 24 is set one cycle after any unmasked message vector is pending. A clearing write cannot remove it while such a vector remains. Masked vectors do not hold it.
- R8: Summary bit 16 is set one cycle after any cause bit is set and unmasked in its own cause mask. A clearing write cannot remove it while such a cause remains.
- R9: `irq_o` equals, one cycle later, summary bit 16 AND NOT summary mask bit 16.
- R10: A mask write stores only the implemented bits. A masked cause still latches in its status register but does not reach the summary bit.
- R11: Word addresses: 0 cause 0, 1 cause 0 mask, 2 cause 1, 3 cause 1 mask, 4 message vectors, 5 message mask, 6 payload (read-only), 7 summary, 8 summary mask. Any other address reads 0, and writes to it or to address 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| leg_assert_i | input | LEGACY_N | Legacy line assert pulses |
| leg_deassert_i | input | LEGACY_N | Legacy line deassert pulses |
| pwr_i | input | 1 | Power-state change pulse |
| flush_i | input | 1 | Flush pulse |
| msi_valid_i | input | 1 | Message arrival pulse |
| msi_vec_i | input | VEC_W | Vector index of the arriving message |
| msi_payload_i | input | PAYLOAD_W | Payload of the arriving message |
| irq_o | output | 1 | Registered level interrupt output |

## Verification
Every legacy line is pulsed in turn on both its assert and its deassert input. The checks confirm that each lands on its own bit in cause 0 and that only asserts reach cause 1. All 32 message vectors are swept with distinct payloads, which separates the vector decode from the payload capture. Multi-bit and partial clearing writes, and a clear that collides with a set in the same cycle, show that the clearing works bit by bit and that a set wins a collision. Cycle-exact checks along the path from cause to summary to output, together with mask changes on the message vectors, the cause bits and the summary bit, show that blocked clears stay blocked exactly while an unmasked source remains.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   // cause 0 field positions
   localparam int C0_LEG_SET_LSB = 16;
   localparam int C0_LEG_CLR_LSB = 20;
   localparam int C0_MSI_BIT     = 24;
   localparam logic [31:0] C0_IMPL = 32'h07FF_FFFF;
   // cause 1 field positions
   localparam int C1_PWR_BIT     = 4;
   localparam int C1_FLUSH_BIT   = 5;
   localparam int C1_LEG_LSB     = 8;
   localparam logic [31:0] C1_IMPL = 32'h0000_0FF0;
   // summary
   localparam int SUM_CORE_BIT   = 16;
   localparam logic [31:0] SUM_IMPL = 32'h0001_0000;
   // word addresses
   localparam int RA_C0_STAT  = 0;
   localparam int RA_C0_MASK  = 1;
   localparam int RA_C1_STAT  = 2;
   localparam int RA_C1_MASK  = 3;
   localparam int RA_MSI_STAT = 4;
   localparam int RA_MSI_MASK = 5;
   localparam int RA_PAYLOAD  = 6;
   localparam int RA_SUM_STAT = 7;
   localparam int RA_SUM_MASK = 8;
endpackage

// File: rtl/irqagg_w1c_reg.sv
module irqagg_w1c_reg #(
   parameter int W = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   // set is applied after clear, so a colliding event survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= ((q_o & ~clr_i) | set_i) & IMPL;
   end
endmodule

// File: rtl/irqagg_mask_reg.sv
module irqagg_mask_reg #(
   parameter int W = 32,
   parameter logic [W-1:0] IMPL = '1,
   parameter logic [W-1:0] RST  = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= RST & IMPL;
      else if (wr_i) q_o <= wdata_i & IMPL;
   end
endmodule

// File: rtl/irqagg_event_map.sv
module irqagg_event_map
   import irqagg_pkg::*;
#(
   parameter int LEGACY_N = 4,
   parameter int MSI_VEC  = 32,
   parameter int VEC_W    = 5
) (
   input  logic [LEGACY_N-1:0] leg_assert_i,
   input  logic [LEGACY_N-1:0] leg_deassert_i,
   input  logic                pwr_i,
   input  logic                flush_i,
   input  logic                msi_valid_i,
   input  logic [VEC_W-1:0]    msi_vec_i,
   input  logic                msi_pend_any_i,
   output logic [31:0]         c0_set_o,
   output logic [31:0]         c1_set_o,
   output logic [MSI_VEC-1:0]  msi_set_o
);
   always_comb begin
      c0_set_o = '0;
      c1_set_o = '0;
      for (int n = 0; n < LEGACY_N; n++) begin
         c0_set_o[C0_LEG_SET_LSB + n] = leg_assert_i[n];
         c0_set_o[C0_LEG_CLR_LSB + n] = leg_deassert_i[n];
         c1_set_o[C1_LEG_LSB + n]     = leg_assert_i[n];
      end
      c0_set_o[C0_MSI_BIT]   = msi_pend_any_i;
      c1_set_o[C1_PWR_BIT]   = pwr_i;
      c1_set_o[C1_FLUSH_BIT] = flush_i;
   end

   for (genvar v = 0; v < MSI_VEC; v++) begin : g_vec
      assign msi_set_o[v] = msi_valid_i && (msi_vec_i == VEC_W'(v));
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irqagg_pkg::*;
#(
   parameter int LEGACY_N  = 4,
   parameter int MSI_VEC   = 32,
   parameter int PAYLOAD_W = 8,
   parameter int ADDR_W    = 4,
   localparam int VEC_W    = (MSI_VEC > 1) ? $clog2(MSI_VEC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_i,
   input  logic [ADDR_W-1:0]    reg_addr_i,
   input  logic [31:0]          reg_wdata_i,
   output logic [31:0]          reg_rdata_o,
   input  logic [LEGACY_N-1:0]  leg_assert_i,
   input  logic [LEGACY_N-1:0]  leg_deassert_i,
   input  logic                 pwr_i,
   input  logic                 flush_i,
   input  logic                 msi_valid_i,
   input  logic [VEC_W-1:0]     msi_vec_i,
   input  logic [PAYLOAD_W-1:0] msi_payload_i,
   output logic                 irq_o
);
   // elaboration-time parameter checks
   if (LEGACY_N < 1 || LEGACY_N > 4) begin : g_bad_legacy
      $error("LEGACY_N must be 1..4");
   end
   if (MSI_VEC < 1 || MSI_VEC > 32) begin : g_bad_vec
      $error("MSI_VEC must be 1..32");
   end
   if (PAYLOAD_W < 1 || PAYLOAD_W > 32) begin : g_bad_payload
      $error("PAYLOAD_W must be 1..32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end

   logic [31:0]          c0_q, c0_mask_q, c1_q, c1_mask_q;
   logic [31:0]          sum_q, sum_mask_q;
   logic [MSI_VEC-1:0]   msi_q, msi_mask_q;
   logic [PAYLOAD_W-1:0] payload_q;
   logic                 irq_q;

   logic [31:0]          c0_set, c1_set, sum_set;
   logic [MSI_VEC-1:0]   msi_set;
   logic                 msi_pend_any, core_any;

   // write decode
   function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
      return a == ADDR_W'(idx);
   endfunction

   logic [31:0] c0_clr, c1_clr, sum_clr, msi_clr_w;
   assign c0_clr    = (reg_wr_i && hit(reg_addr_i, RA_C0_STAT))  ? reg_wdata_i : '0;
   assign c1_clr    = (reg_wr_i && hit(reg_addr_i, RA_C1_STAT))  ? reg_wdata_i : '0;
   assign sum_clr   = (reg_wr_i && hit(reg_addr_i, RA_SUM_STAT)) ? reg_wdata_i : '0;
   assign msi_clr_w = (reg_wr_i && hit(reg_addr_i, RA_MSI_STAT)) ? reg_wdata_i : '0;

   // roll-ups
   assign msi_pend_any = |(msi_q & ~msi_mask_q);
   assign core_any     = (|(c0_q & ~c0_mask_q)) | (|(c1_q & ~c1_mask_q));
   assign sum_set      = 32'(core_any) << SUM_CORE_BIT;

   irqagg_event_map #(
      .LEGACY_N(LEGACY_N), .MSI_VEC(MSI_VEC), .VEC_W(VEC_W)
   ) u_map (
      .leg_assert_i   (leg_assert_i),
      .leg_deassert_i (leg_deassert_i),
      .pwr_i          (pwr_i),
      .flush_i        (flush_i),
      .msi_valid_i    (msi_valid_i),
      .msi_vec_i      (msi_vec_i),
      .msi_pend_any_i (msi_pend_any),
      .c0_set_o       (c0_set),
      .c1_set_o       (c1_set),
      .msi_set_o      (msi_set)
   );

   // status registers
   irqagg_w1c_reg #(.W(32), .IMPL(C0_IMPL)) u_c0 (
      .clk(clk), .rst_n(rst_n), .set_i(c0_set), .clr_i(c0_clr), .q_o(c0_q));
   irqagg_w1c_reg #(.W(32), .IMPL(C1_IMPL)) u_c1 (
      .clk(clk), .rst_n(rst_n), .set_i(c1_set), .clr_i(c1_clr), .q_o(c1_q));
   irqagg_w1c_reg #(.W(32), .IMPL(SUM_IMPL)) u_sum (
      .clk(clk), .rst_n(rst_n), .set_i(sum_set), .clr_i(sum_clr), .q_o(sum_q));
   irqagg_w1c_reg #(.W(MSI_VEC), .IMPL({MSI_VEC{1'b1}})) u_msi (
      .clk(clk), .rst_n(rst_n), .set_i(msi_set),
      .clr_i(msi_clr_w[MSI_VEC-1:0]), .q_o(msi_q));

   // mask registers, all reset to masked
   irqagg_mask_reg #(.W(32), .IMPL(C0_IMPL), .RST('1)) u_c0_mask (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i && hit(reg_addr_i, RA_C0_MASK)),
      .wdata_i(reg_wdata_i), .q_o(c0_mask_q));
   irqagg_mask_reg #(.W(32), .IMPL(C1_IMPL), .RST('1)) u_c1_mask (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i && hit(reg_addr_i, RA_C1_MASK)),
      .wdata_i(reg_wdata_i), .q_o(c1_mask_q));
   irqagg_mask_reg #(.W(32), .IMPL(SUM_IMPL), .RST('1)) u_sum_mask (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i && hit(reg_addr_i, RA_SUM_MASK)),
      .wdata_i(reg_wdata_i), .q_o(sum_mask_q));
   irqagg_mask_reg #(.W(MSI_VEC), .IMPL({MSI_VEC{1'b1}}), .RST({MSI_VEC{1'b1}})) u_msi_mask (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i && hit(reg_addr_i, RA_MSI_MASK)),
      .wdata_i(reg_wdata_i[MSI_VEC-1:0]), .q_o(msi_mask_q));

   // payload capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           payload_q <= '0;
      else if (msi_valid_i) payload_q <= msi_payload_i;
   end

   // registered output level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(sum_q & ~sum_mask_q);
   end
   assign irq_o = irq_q;

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         ADDR_W'(RA_C0_STAT):  reg_rdata_o = c0_q;
         ADDR_W'(RA_C0_MASK):  reg_rdata_o = c0_mask_q;
         ADDR_W'(RA_C1_STAT):  reg_rdata_o = c1_q;
         ADDR_W'(RA_C1_MASK):  reg_rdata_o = c1_mask_q;
         ADDR_W'(RA_MSI_STAT): reg_rdata_o = 32'(msi_q);
         ADDR_W'(RA_MSI_MASK): reg_rdata_o = 32'(msi_mask_q);
         ADDR_W'(RA_PAYLOAD):  reg_rdata_o = 32'(payload_q);
         ADDR_W'(RA_SUM_STAT): reg_rdata_o = sum_q;
         ADDR_W'(RA_SUM_MASK): reg_rdata_o = sum_mask_q;
         default:              reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
   parameter int LEGACY_N  = 4,
   parameter int MSI_VEC   = 32,
   parameter int PAYLOAD_W = 8,
   parameter int VEC_W     = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [LEGACY_N-1:0]  leg_assert_i,
   input logic                 pwr_i,
   input logic                 msi_valid_i,
   input logic [VEC_W-1:0]     msi_vec_i,
   input logic [PAYLOAD_W-1:0] msi_payload_i,
   input logic [31:0]          c0_q,
   input logic [31:0]          c0_mask_q,
   input logic [31:0]          c1_q,
   input logic [31:0]          c1_mask_q,
   input logic [MSI_VEC-1:0]   msi_q,
   input logic [MSI_VEC-1:0]   msi_mask_q,
   input logic [31:0]          sum_q,
   input logic [31:0]          sum_mask_q,
   input logic [PAYLOAD_W-1:0] payload_q,
   input logic                 irq_o
);
   logic chk_core, chk_msi, chk_gate;
   assign chk_core = (|(c0_q & ~c0_mask_q)) || (|(c1_q & ~c1_mask_q));
   assign chk_msi  = |(msi_q & ~msi_mask_q);
   assign chk_gate = sum_q[16] && !sum_mask_q[16];

   AST_LEG_TO_C0: assert property (@(posedge clk) disable iff (!rst_n)
      (|leg_assert_i) |=> ((c0_q[16 +: LEGACY_N] & $past(leg_assert_i)) == $past(leg_assert_i))); // R2
   AST_LEG_TO_C1: assert property (@(posedge clk) disable iff (!rst_n)
      (|leg_assert_i) |=> ((c1_q[8 +: LEGACY_N] & $past(leg_assert_i)) == $past(leg_assert_i))); // R3
   AST_PWR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_i |=> c1_q[4]); // R3
   AST_VEC_SET: assert property (@(posedge clk) disable iff (!rst_n)
      msi_valid_i |=> (((msi_q >> $past(msi_vec_i)) & MSI_VEC'(1)) != '0)); // R6
   AST_PAYLOAD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      msi_valid_i |=> (payload_q == $past(msi_payload_i))); // R6
   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      chk_msi |=> c0_q[24]); // R7
   AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      chk_core |=> sum_q[16]); // R8
   AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
      chk_gate |=> irq_o); // R9
   AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_gate |=> !irq_o); // R9
endmodule

bind irq_aggregator irqagg_checker #(
   .LEGACY_N(LEGACY_N), .MSI_VEC(MSI_VEC), .PAYLOAD_W(PAYLOAD_W), .VEC_W(VEC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .leg_assert_i(leg_assert_i), .pwr_i(pwr_i),
   .msi_valid_i(msi_valid_i), .msi_vec_i(msi_vec_i), .msi_payload_i(msi_payload_i),
   .c0_q(c0_q), .c0_mask_q(c0_mask_q), .c1_q(c1_q), .c1_mask_q(c1_mask_q),
   .msi_q(msi_q), .msi_mask_q(msi_mask_q), .sum_q(sum_q), .sum_mask_q(sum_mask_q),
   .payload_q(payload_q), .irq_o(irq_o)
);

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  leg_a = '0, leg_d = '0;
   logic        pwr = 1'b0, fl = 1'b0, mv = 1'b0;
   logic [4:0]  mvec = '0;
   logic [7:0]  mpl = '0;
   logic        irq;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   irq_aggregator dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(wr_en), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .leg_assert_i(leg_a),
      .leg_deassert_i(leg_d), .pwr_i(pwr), .flush_i(fl), .msi_valid_i(mv),
      .msi_vec_i(mvec), .msi_payload_i(mpl), .irq_o(irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      @(negedge clk); addr = a[3:0]; #1; v = rdata;
   endtask

   task automatic chk_rd(input string req, input int a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, $sformatf("addr %0d", a), v, exp);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a[3:0]; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic evt(input logic [3:0] a, input logic [3:0] d, input logic p,
                      input logic f, input logic m, input logic [4:0] vec,
                      input logic [7:0] pl);
      @(negedge clk); leg_a = a; leg_d = d; pwr = p; fl = f; mv = m; mvec = vec; mpl = pl;
      @(negedge clk); leg_a = '0; leg_d = '0; pwr = 0; fl = 0; mv = 0;
   endtask

   task automatic clear_all();
      wr(0, '1); wr(2, '1); wr(4, '1); wr(0, '1); wr(7, '1); wr(7, '1);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values, R11 unused addresses
      chk("R1", "irq_o", 32'(irq), 32'h0);
      chk_rd("R1", 0, 32'h0);
      chk_rd("R1", 1, 32'h07FF_FFFF);
      chk_rd("R1", 2, 32'h0);
      chk_rd("R1", 3, 32'h0000_0FF0);
      chk_rd("R1", 4, 32'h0);
      chk_rd("R1", 5, 32'hFFFF_FFFF);
      chk_rd("R1", 6, 32'h0);
      chk_rd("R1", 7, 32'h0);
      chk_rd("R1", 8, 32'h0001_0000);
      for (int a = 9; a < 16; a++) chk_rd("R11", a, 32'h0);

      // R10 mask writes keep implemented bits only
      wr(1, '1); chk_rd("R10", 1, 32'h07FF_FFFF);
      wr(3, '1); chk_rd("R10", 3, 32'h0000_0FF0);
      wr(8, '1); chk_rd("R10", 8, 32'h0001_0000);
      wr(1, 0); wr(3, 0); wr(5, 0); wr(8, 0);
      chk_rd("R10", 1, 32'h0);

      // R2 / R3 per-line sweep
      for (int n = 0; n < 4; n++) begin
         evt(4'(1 << n), 4'h0, 0, 0, 0, 5'd0, 8'd0);
         chk_rd("R2", 0, 32'h1 << (16 + n));
         chk_rd("R3", 2, 32'h1 << (8 + n));
         clear_all();
         evt(4'h0, 4'(1 << n), 0, 0, 0, 5'd0, 8'd0);
         chk_rd("R2", 0, 32'h1 << (20 + n));
         chk_rd("R3", 2, 32'h0);
         clear_all();
      end
      evt(4'h0, 4'h0, 1, 0, 0, 5'd0, 8'd0);
      chk_rd("R3", 2, 32'h10);
      clear_all();
      evt(4'h0, 4'h0, 0, 1, 0, 5'd0, 8'd0);
      chk_rd("R3", 2, 32'h20);
      clear_all();
      chk_rd("R4", 0, 32'h0);

      // R4 partial clear, zero write, all-ones clear
      evt(4'h3, 4'h0, 1, 1, 0, 5'd0, 8'd0);
      wr(0, 32'h0001_0000);
      chk_rd("R4", 0, 32'h0002_0000);
      wr(0, 32'h0);
      chk_rd("R4", 0, 32'h0002_0000);
      wr(2, 32'h0000_0010);
      chk_rd("R4", 2, 32'h0000_0320);
      wr(2, '1);
      chk_rd("R4", 2, 32'h0);

      // R5 set wins over a clear in the same cycle
      @(negedge clk); wr_en = 1; addr = 0; wdata = 32'h0006_0000; leg_a = 4'h4;
      @(negedge clk); wr_en = 0; leg_a = 4'h0;
      chk_rd("R5", 0, 32'h0004_0000);
      clear_all();

      // R8 / R9 cycle-exact path from cause to output
      @(negedge clk); pwr = 1;
      @(negedge clk); pwr = 0; addr = 7; #1;        // after edge k
      chk("R9", "irq_o at k", 32'(irq), 32'h0);
      chk("R8", "summary at k", rdata, 32'h0);
      @(negedge clk); #1;                           // after edge k+1
      chk("R8", "summary at k+1", rdata, 32'h0001_0000);
      chk("R9", "irq_o at k+1", 32'(irq), 32'h0);
      @(negedge clk); #1;                           // after edge k+2
      chk("R9", "irq_o at k+2", 32'(irq), 32'h1);
      wr(8, 32'h0001_0000);
      rd(8, v);
      chk("R9", "irq_o with summary masked", 32'(irq), 32'h0);
      wr(8, 0);
      wr(7, '1);
      chk_rd("R8", 7, 32'h0001_0000);
      wr(3, 32'h10);
      wr(7, '1);
      chk_rd("R8", 7, 32'h0);
      chk("R9", "irq_o after clear", 32'(irq), 32'h0);
      wr(3, 0);
      clear_all();

      // R6 vector sweep with payloads; R7 timing on the first vector
      for (int vv = 0; vv < 32; vv++) begin
         logic [7:0] pl;
         pl = 8'((vv * 37 + 5) & 8'hFF);
         evt(4'h0, 4'h0, 0, 0, 1, 5'(vv), pl);
         if (vv == 0) begin
            addr = 0; #1;
            chk("R7", "pending at k", rdata, 32'h0);
            @(negedge clk); #1;
            chk("R7", "pending at k+1", rdata, 32'h0100_0000);
         end
         chk_rd("R6", 4, 32'h1 << vv);
         chk_rd("R6", 6, 32'(pl));
         wr(4, 32'h1 << vv);
         chk_rd("R6", 4, 32'h0);
      end
      clear_all();
      chk_rd("R7", 0, 32'h0);

      // R7 pending bit held until no unmasked vector remains
      evt(4'h0, 4'h0, 0, 0, 1, 5'd3, 8'h11);
      evt(4'h0, 4'h0, 0, 0, 1, 5'd9, 8'h22);
      wr(0, '1);
      chk_rd("R7", 0, 32'h0100_0000);
      wr(4, 32'h8);
      wr(0, '1);
      chk_rd("R7", 0, 32'h0100_0000);
      wr(5, 32'h200);
      wr(0, '1);
      chk_rd("R7", 0, 32'h0);
      chk_rd("R7", 4, 32'h200);
      wr(5, 0);
      clear_all();

      // R11 payload and unused addresses ignore writes
      wr(6, '1);
      chk_rd("R11", 6, 32'h22);
      wr(12, '1);
      chk_rd("R11", 12, 32'h0);
      for (int a = 0; a < 9; a++) begin
         if (a == 1 || a == 3 || a == 5 || a == 8 || a == 6) continue;
         chk_rd("R11", a, 32'h0);
      end

      // R10 masked cause latches but does not reach summary
      wr(1, 32'h0001_0000); wr(3, 32'h0000_0100);
      evt(4'h1, 4'h0, 0, 0, 0, 5'd0, 8'd0);
      chk_rd("R10", 0, 32'h0001_0000);
      chk_rd("R10", 7, 32'h0);
      chk("R10", "irq_o masked cause", 32'(irq), 32'h0);
      wr(1, 0); wr(3, 0);
      clear_all();

      done = 1'b1;
      finish_run();
   end
endmodule